// File: doc/BRIEF.md
# Big-Endian Load Data Formatter

This block sits between a word-organized data memory and the register writeback path of a small 32-bit pipeline. It adds a base register value to a sign-extended 16-bit displacement to form the effective byte address, and drives the word-aligned part of that address to the memory. The memory returns the whole word in the same cycle. The block then picks the addressed byte or halfword in big-endian lane order and widens it to the full register width by sign extension or zero fill.

The access kind says whether the load is a byte, a halfword or a word, and whether it is signed or unsigned. A halfword or word load at an address that does not match its size raises a fault and does not write back. Results leave through a register stage one cycle after the request, together with a valid strobe that follows the request valid input.

Top module: `be_load_formatter`

## Requirements
- R1: `mem_addr_o` equals `base_i` plus the sign-extended `offset_i`, with bits 1:0 forced to zero. It is combinational in the request cycle. The lane inside the word is given by bits 1:0 of the sum.
- R2: `kind_i` bits 1:0 give the size (0 byte, 1 halfword, 2 word) and bit 2 selects unsigned. A word load (`3'b010`) writes the memory word unchanged. The byte at the effective address lands in bits 31:24.
- R3: A signed byte load (`3'b000`) takes lane L from word bits 31-8L down to 24-8L. It places that byte in bits 7:0 and copies its bit 7 into bits 31:8. For example, 0x80 gives 0xFFFFFF80.
- R4: An unsigned byte load (`3'b100`) places the selected byte in bits 7:0 and drives zeros on bits 31:8.
- R5: Halfword loads (`3'b001` signed, `3'b101` unsigned) take word bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1. They fill bits 31:16 with the sign bit or with zeros.
- R6: A halfword load with address bit 0 set, or a word load with address bits 1:0 nonzero, raises `fault_o` with `wb_en_o` low.
- R7: Byte loads never fault, at any address.
- R8: The encodings `3'b011`, `3'b110` and `3'b111` give neither writeback nor fault. `rsp_valid_o` still pulses.
- R9: The outputs are registered. `rsp_valid_o` follows `req_valid_i` one cycle later. `wb_en_o` and `fault_o` are only ever high together with `rsp_valid_o`.
- R10: After reset all outputs are low. Whenever `wb_en_o` is low, `wb_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A load request is present |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| kind_i | input | 3 | Access size and signedness |
| mem_rdata_i | input | 32 | Word read from memory at `mem_addr_o` |
| mem_addr_o | output | 32 | Word-aligned memory address |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| wb_en_o | output | 1 | Write the result to the destination register |
| fault_o | output | 1 | Misaligned access |
| wb_data_o | output | 32 | Formatted load result |

## Verification
The bench sweeps every kind encoding against bases and displacements that reach all four lanes. These include negative displacements and sums that wrap around zero. A design that ignored the displacement's sign, or picked lanes in little-endian order, would return the wrong byte. The data words are chosen so that the selected byte or halfword has its top bit both set and clear in different cases. A swapped sign or zero fill then shows up in the upper bits. Misaligned halfword and word addresses must fault without writeback, byte loads must never fault, and the three unused kinds must do nothing. An idle cycle checks that no stale strobe survives.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned OFF_W = 16;
  localparam int unsigned NB    = XLEN / 8;
  localparam int unsigned LN_W  = $clog2(NB);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } ld_size_e;

  typedef struct packed {
    logic     uns;
    ld_size_e size;
  } ld_kind_t;

  function automatic logic kind_legal(ld_kind_t k);
    return (k.size != SZ_RSVD) && !(k.size == SZ_WORD && k.uns);
  endfunction
endpackage

// File: rtl/ldf_agen.sv
module ldf_agen
  import ldf_pkg::*;
#(
  parameter int unsigned AW   = XLEN,
  parameter int unsigned OW   = OFF_W,
  parameter int unsigned LW   = LN_W
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  ld_kind_t      kind_i,
  output logic [AW-1:0] word_addr_o,
  output logic [LW-1:0] lane_o,
  output logic          misalign_o
);
  logic [AW-1:0] ea;

  assign ea          = base_i + {{(AW-OW){offset_i[OW-1]}}, offset_i};
  assign word_addr_o = {ea[AW-1:LW], {LW{1'b0}}};
  assign lane_o      = ea[LW-1:0];

  always_comb begin
    unique case (kind_i.size)
      SZ_HALF: misalign_o = ea[0];
      SZ_WORD: misalign_o = |ea[LW-1:0];
      default: misalign_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldf_extract.sv
module ldf_extract
  import ldf_pkg::*;
#(
  parameter int unsigned DW = XLEN,
  parameter int unsigned LW = LN_W
) (
  input  logic [DW-1:0] word_i,
  input  logic [LW-1:0] lane_i,
  input  ld_kind_t      kind_i,
  output logic [DW-1:0] data_o
);
  localparam int unsigned NBY = DW / 8;
  localparam int unsigned NHW = DW / 16;

  logic [7:0]  bytes [NBY];
  logic [15:0] halves[NHW];

  // big-endian lanes: lane 0 is the most significant slice
  for (genvar i = 0; i < NBY; i++) begin : g_byte
    assign bytes[i] = word_i[DW-1-8*i -: 8];
  end
  for (genvar j = 0; j < NHW; j++) begin : g_half
    assign halves[j] = word_i[DW-1-16*j -: 16];
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  assign sel_b = bytes[lane_i];
  assign sel_h = halves[lane_i[LW-1:1]];

  always_comb begin
    unique case (kind_i.size)
      SZ_BYTE: data_o = {{(DW-8){sel_b[7] & ~kind_i.uns}}, sel_b};
      SZ_HALF: data_o = {{(DW-16){sel_h[15] & ~kind_i.uns}}, sel_h};
      SZ_WORD: data_o = word_i;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/be_load_formatter.sv
module be_load_formatter
  import ldf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [2:0]       kind_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic             rsp_valid_o,
  output logic             wb_en_o,
  output logic             fault_o,
  output logic [XLEN-1:0]  wb_data_o
);
  ld_kind_t        kind;
  logic [LN_W-1:0] lane;
  logic            misalign;
  logic            legal;
  logic [XLEN-1:0] fmt_data;
  logic            wb_d, fault_d;

  assign kind = ld_kind_t'(kind_i);

  ldf_agen #(.AW(XLEN), .OW(OFF_W), .LW(LN_W)) u_agen (
    .base_i      (base_i),
    .offset_i    (offset_i),
    .kind_i      (kind),
    .word_addr_o (mem_addr_o),
    .lane_o      (lane),
    .misalign_o  (misalign)
  );

  ldf_extract #(.DW(XLEN), .LW(LN_W)) u_ext (
    .word_i (mem_rdata_i),
    .lane_i (lane),
    .kind_i (kind),
    .data_o (fmt_data)
  );

  assign legal   = kind_legal(kind);
  assign wb_d    = req_valid_i & legal & ~misalign;
  assign fault_d = req_valid_i & legal & misalign;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      wb_en_o     <= 1'b0;
      fault_o     <= 1'b0;
      wb_data_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      wb_en_o     <= wb_d;
      fault_o     <= fault_d;
      wb_data_o   <= wb_d ? fmt_data : '0;
    end
  end
endmodule

// File: rtl/ldf_checker.sv
module ldf_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [2:0]  kind_i,
  input logic        rsp_valid_o,
  input logic        wb_en_o,
  input logic        fault_o,
  input logic [31:0] wb_data_o
);
  logic seen;
  logic prev_byte, prev_ubyte, prev_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen       <= 1'b0;
      prev_byte  <= 1'b0;
      prev_ubyte <= 1'b0;
      prev_valid <= 1'b0;
    end else begin
      seen       <= 1'b1;
      prev_valid <= req_valid_i;
      prev_byte  <= req_valid_i && kind_i[1:0] == 2'd0;
      prev_ubyte <= req_valid_i && kind_i == 3'b100;
    end
  end

  p_fault_blocks_wb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && wb_en_o));
  p_strobe_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> rsp_valid_o == prev_valid);
  p_flags_need_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o || fault_o) |-> rsp_valid_o);
  p_byte_nofault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && prev_byte) |-> !fault_o);
  p_ubyte_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && prev_ubyte && wb_en_o) |-> wb_data_o[31:8] == 24'h0);
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_en_o |-> wb_data_o == 32'h0);
endmodule

bind be_load_formatter ldf_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .kind_i      (kind_i),
  .rsp_valid_o (rsp_valid_o),
  .wb_en_o     (wb_en_o),
  .fault_o     (fault_o),
  .wb_data_o   (wb_data_o)
);

// File: tb/tb_be_load_formatter.sv
module tb_be_load_formatter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic [2:0]  kind_i = '0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] mem_addr_o;
  logic        rsp_valid_o, wb_en_o, fault_o;
  logic [31:0] wb_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  be_load_formatter dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] k);
    case (k)
      3'b010: return "R2";
      3'b000: return "R3";
      3'b100: return "R4";
      3'b001, 3'b101: return "R5";
      default: return "R8";
    endcase
  endfunction

  logic [31:0] bases [4] = '{32'h0000_1000, 32'h0000_1001, 32'h0000_2003, 32'hFFFF_FFFE};
  logic [15:0] offs  [6] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'hFFFE, 16'h8001};
  logic [31:0] datas [3] = '{32'h1122_3344, 32'h80FF_7F12, 32'hFF80_0080};

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset", {rsp_valid_o, wb_en_o, fault_o}, 32'h0);
    chk("R10 reset data", wb_data_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < 4; b++) begin
        for (int o = 0; o < 6; o++) begin
          for (int d = 0; d < 3; d++) begin
            logic [31:0] ea, exp_d;
            logic [7:0]  by;
            logic [15:0] hw;
            logic        legal, mis, exp_wb;
            logic [2:0]  kk;
            kk = 3'(k);
            req_valid_i = 1'b1;
            base_i      = bases[b];
            offset_i    = offs[o];
            kind_i      = kk;
            mem_rdata_i = datas[d];
            ea = bases[b] + {{16{offs[o][15]}}, offs[o]};
            by = datas[d][31 - 8*ea[1:0] -: 8];
            hw = ea[1] ? datas[d][15:0] : datas[d][31:16];
            legal = (kk[1:0] != 2'd3) && (kk != 3'b110);
            mis = (kk[1:0] == 2'd1) ? ea[0] : (kk[1:0] == 2'd2) ? (ea[1:0] != 2'd0) : 1'b0;
            case (kk[1:0])
              2'd0: exp_d = kk[2] ? {24'h0, by} : {{24{by[7]}}, by};
              2'd1: exp_d = kk[2] ? {16'h0, hw} : {{16{hw[15]}}, hw};
              default: exp_d = datas[d];
            endcase
            exp_wb = legal && !mis;
            if (!exp_wb) exp_d = 32'h0;
            #1;
            chk("R1 addr", mem_addr_o, {ea[31:2], 2'b00});
            @(negedge clk_i);
            chk("R9 valid", {31'h0, rsp_valid_o}, 32'h1);
            chk({tag_of(kk), " data"}, wb_data_o, exp_d);
            chk(kk[1:0] == 2'd0 ? "R7 byte wb" : (legal ? "R6 wb" : "R8 wb"),
                {31'h0, wb_en_o}, {31'h0, exp_wb});
            chk(kk[1:0] == 2'd0 ? "R7 nofault" : (legal ? "R6 fault" : "R8 fault"),
                {31'h0, fault_o}, {31'h0, legal && mis});
          end
        end
      end
    end
    req_valid_i = 1'b0;
    kind_i = 3'b010;
    base_i = 32'h1004;
    offset_i = 16'h0;
    @(negedge clk_i);
    chk("R9 idle", {rsp_valid_o, wb_en_o, fault_o}, 32'h0);
    chk("R10 idle data", wb_data_o, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule